// File: doc/BRIEF.md
# Receive Byte Queue with Resident Error Tallies

This block is the receive-side holding queue of a serial port. The receiver pushes each incoming byte together with two flags: one for a parity fault and one for a framing fault. The CPU side pops bytes in arrival order. Each pop returns the byte and both of its fault flags.

Alongside the queue, the block keeps two tallies. Each tally counts how many bytes that are *currently stored* carry one kind of fault. A tally goes up when a faulty byte enters and goes down when it leaves. The tallies are therefore not lifetime totals. Both are packed into a 16-bit read-only status word that can be sampled at any time.

A sticky summary flag tells software that a faulty byte has arrived. Once that flag is set, the tallies can be trusted. Further outputs are a sticky overrun flag, the fill level, and empty and full indications.

Top module: `rxerr_fifo`

## Requirements
- R1: After reset, the fill level is 0, empty is 1, full is 0, the status word is 0, and the summary and overrun flags are 0.
- R2: Bytes leave in the order they were accepted. After an accepted pop, the pop data, parity flag and framing flag outputs show the departing entry from the clock edge that sampled the pop until the next accepted pop.
- R3: The fill level counts stored bytes from 0 to 64. Empty is 1 exactly at level 0 and full is 1 exactly at level 64. Pushing and popping in the same cycle, when both are accepted, leaves the level unchanged.
- R4: Status bits 13..8 hold the number of stored bytes whose parity flag is set. An accepted push of such a byte adds 1, an accepted pop of such a byte subtracts 1, and a simultaneous push and pop applies the net change.
- R5: Status bits 5..0 hold the number of stored bytes whose framing flag is set, and they update by the same push, pop and net rules as R4.
- R6: Status bits 15, 14, 7 and 6 always read 0.
- R7: Each tally is 6 bits wide and counts modulo 64. With 64 stored bytes that all carry a fault, that tally reads 0, and with 63 such bytes it reads 63.
- R8: A push while full is dropped and leaves the contents and the tallies unchanged. It also sets the overrun flag, which stays set until reset.
- R9: A pop while empty is ignored. The pop data and flag outputs keep their previous values.
- R10: The summary flag is set by an accepted push whose parity or framing flag is set. It stays set until a cycle with the clear input high and no such push. If a push sets the flag in the same cycle as a clear, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push request from the receiver |
| push_data_i | input | 8 | Received byte |
| push_perr_i | input | 1 | Parity fault flag of the received byte |
| push_ferr_i | input | 1 | Framing fault flag of the received byte |
| pop_i | input | 1 | Pop request from the CPU side |
| pop_data_o | output | 8 | Most recently popped byte |
| pop_perr_o | output | 1 | Parity fault flag of the most recently popped byte |
| pop_ferr_o | output | 1 | Framing fault flag of the most recently popped byte |
| err_clr_i | input | 1 | Clears the summary fault flag |
| err_flag_o | output | 1 | Sticky summary fault flag |
| overrun_o | output | 1 | Sticky flag: a push was dropped while full |
| level_o | output | 7 | Number of stored bytes |
| empty_o | output | 1 | Queue holds no bytes |
| full_o | output | 1 | Queue holds 64 bytes |
| stat_o | output | 16 | Status word: parity tally in bits 13..8, framing tally in bits 5..0 |

## Verification
Every registered result of this block becomes visible at the rising edge that samples the push, pop or clear. This covers the level, the flags, both tallies and the popped entry, so each result is due one edge after its stimulus.

The bench drives its inputs on the falling edge and updates its reference model 1 ns after the following rising edge. Status, level and flags are compared at that point. Popped entries are compared by a monitor on the next falling edge against the head of an expected-entry queue, which the driver fills only after the edge that accepted the pop.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
   localparam int STAT_W  = 16;
   localparam int FIELD_W = 6;
   localparam int PAR_LSB = 8;
   localparam int FRM_LSB = 0;
   localparam int NUM_KINDS = 2;
   // index of each fault kind; also its bit offset above the data byte
   localparam int KIND_FRM = 0;
   localparam int KIND_PAR = 1;
endpackage

// File: rtl/rxerr_store.sv
// Entry storage: one write port, combinational read of the head entry.
module rxerr_store #(
   parameter int WORD_W = 10,
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] head_word
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_word;
   end

   assign head_word = mem[rd_addr];
endmodule

// File: rtl/rxerr_ptrs.sv
// Read/write pointers and fill level; decides which requests are accepted.
module rxerr_ptrs #(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_req,
   input  logic          pop_req,
   output logic          push_ok,
   output logic          pop_ok,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic [LW-1:0] level,
   output logic          empty,
   output logic          full
);
   assign empty   = (level == '0);
   assign full    = (level == LW'(DEPTH));
   assign push_ok = push_req && !full;
   assign pop_ok  = pop_req && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/rxerr_tally.sv
// Modulo up/down counter of resident faulty entries.
module rxerr_tally #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [CW-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         case ({inc, dec})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/rxerr_fifo.sv
module rxerr_fifo
   import rxerr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH),
   localparam int LW    = AW + 1,
   localparam int WORD_W = DATA_W + NUM_KINDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              push_perr_i,
   input  logic              push_ferr_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] pop_data_o,
   output logic              pop_perr_o,
   output logic              pop_ferr_o,
   input  logic              err_clr_i,
   output logic              err_flag_o,
   output logic              overrun_o,
   output logic [LW-1:0]     level_o,
   output logic              empty_o,
   output logic              full_o,
   output logic [STAT_W-1:0] stat_o
);
   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rxerr_fifo: DEPTH must be a power of two >= 2");
   end
   if (AW > FIELD_W) begin : g_bad_field
      $error("rxerr_fifo: tally does not fit its status field");
   end
   if (DATA_W < 1 || DATA_W > PAR_LSB) begin : g_bad_data
      $error("rxerr_fifo: DATA_W out of range");
   end

   logic              push_ok, pop_ok;
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic [WORD_W-1:0] wr_word, head_word;
   logic [AW-1:0]     tally [NUM_KINDS];

   // entry layout: {parity flag, framing flag, data}
   assign wr_word = {push_perr_i, push_ferr_i, push_data_i};

   rxerr_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (push_i),
      .pop_req  (pop_i),
      .push_ok  (push_ok),
      .pop_ok   (pop_ok),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .level    (level_o),
      .empty    (empty_o),
      .full     (full_o)
   );

   rxerr_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .wr_en     (push_ok),
      .wr_addr   (wr_ptr),
      .wr_word   (wr_word),
      .rd_addr   (rd_ptr),
      .head_word (head_word)
   );

   // one tally per fault kind
   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_tally
      rxerr_tally #(.CW(AW)) u_tally (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (push_ok && wr_word[DATA_W + k]),
         .dec   (pop_ok && head_word[DATA_W + k]),
         .count (tally[k])
      );
   end

   // status word packing; narrower tallies are zero-extended
   always_comb begin
      stat_o = '0;
      stat_o[PAR_LSB +: FIELD_W] = FIELD_W'(tally[KIND_PAR]);
      stat_o[FRM_LSB +: FIELD_W] = FIELD_W'(tally[KIND_FRM]);
   end

   // registered read port: holds the last popped entry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_data_o <= '0;
         pop_perr_o <= 1'b0;
         pop_ferr_o <= 1'b0;
      end else if (pop_ok) begin
         pop_data_o <= head_word[DATA_W-1:0];
         pop_ferr_o <= head_word[DATA_W + KIND_FRM];
         pop_perr_o <= head_word[DATA_W + KIND_PAR];
      end
   end

   // sticky flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_flag_o <= 1'b0;
         overrun_o  <= 1'b0;
      end else begin
         if (push_ok && (push_perr_i || push_ferr_i)) err_flag_o <= 1'b1;
         else if (err_clr_i)                          err_flag_o <= 1'b0;
         if (push_i && !push_ok) overrun_o <= 1'b1;
      end
   end
endmodule

// File: rtl/rxerr_fifo_chk.sv
module rxerr_fifo_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int LW    = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_i,
   input logic              push_perr_i,
   input logic              push_ferr_i,
   input logic              pop_i,
   input logic [DATA_W-1:0] pop_data_o,
   input logic              err_flag_o,
   input logic              overrun_o,
   input logic [LW-1:0]     level_o,
   input logic              empty_o,
   input logic              full_o,
   input logic [15:0]       stat_o
);
   assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      level_o <= LW'(DEPTH));

   assert_level_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && !pop_i && !full_o |=> level_o == $past(level_o) + 1'b1);

   assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !push_i && !pop_i |=> $stable(stat_o) && $stable(level_o));

   assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      full_o && push_i && !pop_i |=> $stable(level_o) && $stable(stat_o) && overrun_o);

   assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |=> overrun_o);

   assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && empty_o |=> $stable(pop_data_o));

   assert_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag_o) |-> $past(push_i && (push_perr_i || push_ferr_i)));
endmodule

bind rxerr_fifo rxerr_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_i      (push_i),
   .push_perr_i (push_perr_i),
   .push_ferr_i (push_ferr_i),
   .pop_i       (pop_i),
   .pop_data_o  (pop_data_o),
   .err_flag_o  (err_flag_o),
   .overrun_o   (overrun_o),
   .level_o     (level_o),
   .empty_o     (empty_o),
   .full_o      (full_o),
   .stat_o      (stat_o)
);

// File: tb/rxerr_fifo_test.sv
`timescale 1ns/1ps
module rxerr_fifo_test;
   localparam int DEPTH = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push_i = 1'b0, push_perr_i = 1'b0, push_ferr_i = 1'b0;
   logic [7:0] push_data_i = '0;
   logic       pop_i = 1'b0, err_clr_i = 1'b0;
   logic [7:0] pop_data_o;
   logic       pop_perr_o, pop_ferr_o, err_flag_o, overrun_o, empty_o, full_o;
   logic [6:0] level_o;
   logic [15:0] stat_o;

   int n_chk = 0;
   int n_err = 0;

   // reference model: entries are {parity, framing, data}
   logic [9:0] m_q [$];
   logic [9:0] exp_q [$];
   logic       m_flag = 1'b0;
   logic       m_ovr  = 1'b0;

   always #10 clk = ~clk;

   rxerr_fifo uut (
      .clk(clk), .rst_n(rst_n),
      .push_i(push_i), .push_data_i(push_data_i),
      .push_perr_i(push_perr_i), .push_ferr_i(push_ferr_i),
      .pop_i(pop_i), .pop_data_o(pop_data_o),
      .pop_perr_o(pop_perr_o), .pop_ferr_o(pop_ferr_o),
      .err_clr_i(err_clr_i), .err_flag_o(err_flag_o), .overrun_o(overrun_o),
      .level_o(level_o), .empty_o(empty_o), .full_o(full_o), .stat_o(stat_o)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: compares popped entries against the expected queue
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [9:0] e;
         e = exp_q.pop_front();
         check("R2 pop order", {22'd0, pop_perr_o, pop_ferr_o, pop_data_o}, {22'd0, e});
      end
   end

   // driver: one cycle of stimulus, model updated after the sampling edge
   task automatic step(bit pu, bit po, logic [7:0] d, bit p, bit f, bit clr);
      bit acc_pu, acc_po;
      @(negedge clk);
      push_i = pu; pop_i = po; push_data_i = d;
      push_perr_i = p; push_ferr_i = f; err_clr_i = clr;
      acc_pu = pu && (m_q.size() < DEPTH);
      acc_po = po && (m_q.size() > 0);
      @(posedge clk);
      #1;
      if (acc_po) exp_q.push_back(m_q.pop_front());
      if (acc_pu) m_q.push_back({p, f, d});
      if (acc_pu && (p || f)) m_flag = 1'b1;
      else if (clr) m_flag = 1'b0;
      if (pu && !acc_pu) m_ovr = 1'b1;
   endtask

   task automatic idle();
      step(0, 0, 8'h00, 0, 0, 0);
   endtask

   task automatic chk_all(string tag);
      int pc = 0, fc = 0;
      foreach (m_q[i]) begin
         pc += m_q[i][9];
         fc += m_q[i][8];
      end
      check({tag, " R3 level"}, {25'd0, level_o}, m_q.size());
      check({tag, " R3 empty"}, {31'd0, empty_o}, {31'd0, m_q.size() == 0});
      check({tag, " R3 full"},  {31'd0, full_o},  {31'd0, m_q.size() == DEPTH});
      check({tag, " R4 parity tally"},  {26'd0, stat_o[13:8]}, pc % 64);
      check({tag, " R5 framing tally"}, {26'd0, stat_o[5:0]},  fc % 64);
      check({tag, " R6 reserved"}, {28'd0, stat_o[15:14], stat_o[7:6]}, 0);
      check({tag, " R10 flag"}, {31'd0, err_flag_o}, {31'd0, m_flag});
      check({tag, " R8 overrun"}, {31'd0, overrun_o}, {31'd0, m_ovr});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [9:0] last;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      chk_all("R1 reset");
      check("R1 pop data", {22'd0, pop_perr_o, pop_ferr_o, pop_data_o}, 0);

      // mixed entries: R4 R5 tallies and R2 order
      step(1, 0, 8'hA1, 1, 0, 0);
      step(1, 0, 8'hB2, 0, 1, 0);
      step(1, 0, 8'hC3, 1, 1, 0);
      step(1, 0, 8'hD4, 0, 0, 0);
      step(1, 0, 8'h15, 1, 0, 0);
      chk_all("mixed push");
      step(0, 1, 8'h00, 0, 0, 0);
      chk_all("pop one");
      step(0, 1, 8'h00, 0, 0, 0);
      chk_all("pop two");

      // simultaneous push and pop, net tally change R4 R5
      step(1, 1, 8'h66, 0, 1, 0);
      chk_all("push+pop net");
      step(1, 1, 8'h77, 1, 0, 0);
      chk_all("push+pop net 2");
      idle();

      // drain then pop while empty R9
      while (m_q.size() > 0) step(0, 1, 8'h00, 0, 0, 0);
      idle();
      chk_all("drained");
      last = {pop_perr_o, pop_ferr_o, pop_data_o};
      step(0, 1, 8'h00, 0, 0, 0);
      check("R9 empty pop hold", {22'd0, pop_perr_o, pop_ferr_o, pop_data_o}, {22'd0, last});
      chk_all("R9 empty pop");

      // summary flag clear and set-wins R10
      step(0, 0, 8'h00, 0, 0, 1);
      chk_all("R10 cleared");
      step(1, 0, 8'h3C, 0, 0, 1);
      chk_all("R10 clean push");
      step(1, 0, 8'h3D, 1, 0, 1);
      chk_all("R10 set wins");
      step(0, 1, 8'h00, 0, 0, 0);
      step(0, 1, 8'h00, 0, 0, 0);
      idle();
      chk_all("refilled empty");

      // fill with all-faulty bytes: wrap R7, full R3
      for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 8'(i), 1, 1, 0);
      chk_all("R7 at 63");
      check("R7 parity 63", {26'd0, stat_o[13:8]}, 63);
      step(1, 0, 8'h3F, 1, 1, 0);
      chk_all("R7 at 64");
      check("R7 parity wraps", {26'd0, stat_o[13:8]}, 0);
      check("R7 framing wraps", {26'd0, stat_o[5:0]}, 0);

      // push while full is dropped R8
      step(1, 0, 8'hEE, 0, 0, 0);
      chk_all("R8 overrun");
      step(0, 0, 8'h00, 0, 0, 1);
      chk_all("R8 sticky");

      // drain: monitor confirms the dropped byte never appears
      while (m_q.size() > 0) step(0, 1, 8'h00, 0, 0, 0);
      idle();
      chk_all("final");

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule